// File: doc/BRIEF.md
# Two-wire mode serial shift engine

This block is the shifting core of a serial port that has been put into a two-wire (I2C-style) mode. It moves 9-bit frames, most significant bit first, on an open-drain data line (SDA). The clock line (SCL) is either made inside the block from a half-period `tick` strobe or taken from the pin. Each frame is received at the same time as it is sent. Both lines are modelled as a drive-low enable plus a sampled input. Each sampled input passes through a two-flop synchronizer.

A clock-phase select (`ckph`) sets three things: the level SCL rests at, the point where the transfer interrupt pulses, and how many times the receive shift register is copied into the receive buffer. Four register-style inputs act on the pins:
- `scl_wait` stretches SCL low after the ninth bit's falling edge.
- `scl_force` pulls SCL low at any time.
- `sda_off` floats SDA at once.
- `sda_dly` delays every SDA change by a programmable number of system clocks.

Edges are numbered per frame: bit k owns one falling edge F_k and one rising edge R_k. Every frame has 18 SCL edges. With `ckph`=0 the order is F1 R1 … F9 R9. With `ckph`=1 the line is already low, so the order is R1 F2 R2 … F9 R9 F10.

Top module: `iic_shift_engine`

## Requirements
- R1: The frame goes out on SDA as D8 first and D0 last. `sda_oe`=1 drives a 0 and `sda_oe`=0 releases the line to 1. Each bit is set up while SCL is low and holds its value across the following SCL rise.
- R2: With the internal clock and the engine idle, SCL rests high for `ckph`=0 (`scl_oe`=0) and low for `ckph`=1 (`scl_oe`=1). It is back at that level after every frame.
- R3: `xfer_irq` pulses for one cycle at the 18th SCL edge of a frame. That edge is R9 for `ckph`=0 and F10 for `ckph`=1.
- R4: With `ckph`=0 the receive buffer is written exactly once, at F9 (the 17th edge). The value written is {0, D8..D1}.
- R5: With `ckph`=1 the receive buffer is written twice. The first write is at F9 (the 16th edge) with value {0, D8..D1}. The second is at R9 (the 17th edge) with value D8..D0. Each write pulses `rx_load`.
- R6: If `scl_wait` is 1 at F9, the engine holds `scl_oe`=1 and makes no further progress until `scl_wait` is cleared. The frame then completes.
- R7: `scl_force`=1 makes `scl_oe`=1 in the same cycle, even in the middle of a frame. Clearing it gives normal clocking back.
- R8: `sda_off`=1 makes `sda_oe`=0 in the same cycle, whatever bit is being sent.
- R9: `sda_dly`=0 applies no delay: an SDA change appears in the same cycle as the SCL fall that causes it. A code c from 1 to 7 delays every SDA change by c+1 system clocks.
- R10: An accepted start clears the receive shift register. Bit 8 of the first buffer write of a frame is therefore 0, even when the previous frame ended in a 1.
- R11: `busy` rises in the cycle after an accepted start and falls together with `xfer_irq`. A start pulse while `busy`=1 is ignored and leaves the frame's data unchanged.
- R12: With `int_clk`=0 the engine drives no clock. It steps on synchronized edges of `scl_in` and transmits and receives the frame as in R1, R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| int_clk | input | 1 | 1: SCL generated from `tick`; 0: SCL taken from the pin |
| ckph | input | 1 | Clock-phase select |
| tick | input | 1 | One-cycle strobe marking each internal SCL half period |
| start | input | 1 | Start request, with `tx_data` valid |
| tx_data | input | 9 | Frame to send |
| scl_wait | input | 1 | Hold SCL low after F9 |
| scl_force | input | 1 | Pull SCL low now |
| sda_off | input | 1 | Float SDA now |
| sda_dly | input | 3 | SDA delay code |
| scl_in | input | 1 | Sampled SCL pin |
| sda_in | input | 1 | Sampled SDA pin |
| scl_oe | output | 1 | Drive SCL low |
| sda_oe | output | 1 | Drive SDA low |
| rx_buf | output | 9 | Receive buffer |
| rx_load | output | 1 | Pulse on each receive buffer write |
| xfer_irq | output | 1 | Transfer interrupt pulse |
| busy | output | 1 | Frame in progress |

## Verification
The SCL hold and the first receive-buffer write happen in the same cycle: the F9 step that arms the hold also copies the shift register. The bench raises `scl_wait` before the frame starts. It then checks that the copy lands with the expected value and edge count, that SCL stays low for sixty cycles with no further edges, and that the frame finishes after the wait is cleared. This is done for both clock phases.

A second overlap is a start request arriving mid-frame. The bench judges it by checking that the data bits on the line and the buffer contents still match the first word.

// File: rtl/iic_shift_engine.sv
module iic_shift_engine #(
  parameter int W  = 9,
  parameter int DW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          int_clk,
  input  logic          ckph,
  input  logic          tick,
  input  logic          start,
  input  logic [W-1:0]  tx_data,
  input  logic          scl_wait,
  input  logic          scl_force,
  input  logic          sda_off,
  input  logic [DW-1:0] sda_dly,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic [W-1:0]  rx_buf,
  output logic          rx_load,
  output logic          xfer_irq,
  output logic          busy
);
  localparam int LAST  = 2*W - 1;
  localparam int HW    = $clog2(2*W);
  localparam int DEPTH = 1 << DW;

  logic [HW-1:0]    h;
  logic [W-1:0]     tsh, rsh;
  logic             scl_lvl, hold, sda_bit;
  logic [2:0]       scl_sy;
  logic [1:0]       sda_sy;
  logic [DEPTH-1:0] dline;

  wire ext_edge = scl_sy[2] ^ scl_sy[1];
  wire go       = start & ~busy;
  wire step     = busy & ~hold & (int_clk ? tick : ext_edge);
  wire rise     = ckph ? ~h[0] : h[0];
  wire last     = (h == HW'(LAST));
  wire fall_w   = ckph ? (h == HW'(LAST-2)) : (h == HW'(LAST-1));
  wire rise_w   = ckph & (h == HW'(LAST-1));
  wire present  = ~rise & ~(ckph & last);
  wire sda_q    = (sda_dly == '0) ? sda_bit : dline[sda_dly];

  assign scl_oe = scl_force | hold | (int_clk & ~scl_lvl);
  assign sda_oe = ~sda_off & ~sda_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      dline  <= '1;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      dline  <= {dline[DEPTH-2:0], sda_bit};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy     <= 1'b0;
      h        <= '0;
      tsh      <= '0;
      rsh      <= '0;
      scl_lvl  <= 1'b1;
      hold     <= 1'b0;
      sda_bit  <= 1'b1;
      rx_buf   <= '0;
      rx_load  <= 1'b0;
      xfer_irq <= 1'b0;
    end else begin
      rx_load  <= 1'b0;
      xfer_irq <= 1'b0;
      if (hold && !scl_wait) hold <= 1'b0;
      if (!busy) scl_lvl <= ~ckph;
      if (go) begin
        busy    <= 1'b1;
        h       <= '0;
        rsh     <= '0;
        scl_lvl <= ~ckph;
        if (ckph) begin
          sda_bit <= tx_data[W-1];
          tsh     <= tx_data << 1;
        end else begin
          tsh     <= tx_data;
        end
      end else if (step) begin
        scl_lvl <= ~scl_lvl;
        h       <= h + 1'b1;
        if (rise) rsh <= {rsh[W-2:0], sda_sy[1]};
        if (present) begin
          sda_bit <= tsh[W-1];
          tsh     <= tsh << 1;
        end
        if (fall_w) begin
          rx_buf  <= rsh;
          rx_load <= 1'b1;
          if (scl_wait) hold <= 1'b1;
        end
        if (rise_w) begin
          rx_buf  <= {rsh[W-2:0], sda_sy[1]};
          rx_load <= 1'b1;
        end
        if (last) begin
          busy     <= 1'b0;
          xfer_irq <= 1'b1;
          h        <= '0;
        end
      end
    end

  p_irq_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_irq |-> !busy);
  p_busy_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> xfer_irq);
  p_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && h == '0));
  p_hold_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && busy) |=> $stable(h));
  p_load_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |-> busy);
  p_load_not_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_irq |-> !rx_load);
  p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && int_clk && !scl_force && !hold && $stable(ckph) &&
     $past(!busy) && $past(rst_n)) |-> (scl_oe == ckph));
endmodule

// File: tb/tb_iic_shift_engine.sv
module tb_iic_shift_engine;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0, ext = 1'b0, ckph = 1'b0, tick = 1'b0, start = 1'b0;
  logic [8:0] tx_data = '0;
  logic       scl_wait = 1'b0, scl_force = 1'b0, sda_off = 1'b0;
  logic [2:0] sda_dly = '0;
  logic       m_scl = 1'b1;
  wire        int_clk = ~ext;
  wire        scl_oe, sda_oe, rx_load, xfer_irq, busy;
  wire [8:0]  rx_buf;
  wire        scl_pin = (ext ? m_scl : 1'b1) & ~scl_oe;
  wire        sda_pin = ~sda_oe;

  iic_shift_engine dut (
    .clk(clk), .rst_n(rst_n), .int_clk(int_clk), .ckph(ckph), .tick(tick),
    .start(start), .tx_data(tx_data), .scl_wait(scl_wait), .scl_force(scl_force),
    .sda_off(sda_off), .sda_dly(sda_dly), .scl_in(scl_pin), .sda_in(sda_pin),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_buf(rx_buf), .rx_load(rx_load),
    .xfer_irq(xfer_irq), .busy(busy));

  int total = 0, bad = 0, cyc = 0, tcnt = 0;
  int edges = 0, rises = 0, loads = 0, irqs = 0, dchg = 0, last_fall = 0, exp_d = 0;
  bit mon_on = 0, chk_dly = 0, wd = 0, cur_ck = 0;
  logic [8:0] cur_tx = '0;
  logic p_scl = 1'b1, p_sda = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(negedge clk) begin
    tick <= (tcnt % 16 == 15);
    tcnt <= tcnt + 1;
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000 && !wd) begin
      wd = 1;
      chk(0, "watchdog", cyc, 150000);
      report();
    end
    if (mon_on) begin
      if (scl_pin != p_scl) begin
        edges++;
        if (scl_pin) begin
          if (rises < 9)
            chk(sda_pin == cur_tx[8-rises], "R1 bit at SCL rise", sda_pin, cur_tx[8-rises]);
          rises++;
        end else last_fall = cyc;
      end
      if (chk_dly && sda_oe != p_sda) begin
        dchg++;
        chk(cyc - last_fall == exp_d, "R9 SDA delay", cyc - last_fall, exp_d);
      end
      if (rx_load) begin
        loads++;
        if (loads == 1) begin
          chk(edges == (cur_ck ? 16 : 17), cur_ck ? "R5 first copy edge" : "R4 copy edge",
              edges, cur_ck ? 16 : 17);
          chk(rx_buf == {1'b0, cur_tx[8:1]}, cur_ck ? "R5 first copy value" : "R4 copy value",
              rx_buf, {1'b0, cur_tx[8:1]});
          chk(rx_buf[8] == 1'b0, "R10 shift register cleared", rx_buf[8], 0);
        end else begin
          chk(cur_ck && edges == 17, "R5 second copy edge", edges, 17);
          chk(rx_buf == cur_tx, "R5 second copy value", rx_buf, cur_tx);
        end
      end
      if (xfer_irq) begin
        irqs++;
        chk(edges == 18, "R3 interrupt edge", edges, 18);
      end
    end
    p_scl = scl_pin;
    p_sda = sda_oe;
  end

  task automatic run_frame(input bit ck, input bit e, input logic [8:0] d, input int dly,
                           input bit dk, input bit inj, input bit wt, input bit frc);
    int guard = 0, tog = 0;
    bit waited = 0;
    @(negedge clk);
    mon_on = 0;
    ckph = ck; ext = e; m_scl = ~ck; sda_dly = 3'(dly); scl_wait = wt;
    repeat (6) @(negedge clk);
    edges = 0; rises = 0; loads = 0; irqs = 0; dchg = 0;
    cur_tx = d; cur_ck = ck; chk_dly = dk; exp_d = (dly == 0) ? 0 : dly + 1;
    mon_on = !frc;
    tx_data = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11 busy after start", busy, 1);
    while (busy && guard < 2000) begin
      @(negedge clk);
      guard++;
      if (e && guard >= 8 && (guard - 8) % 16 == 0 && tog < 18) begin
        m_scl = ~m_scl;
        tog++;
      end
      if (inj && guard == 40) begin
        tx_data = ~d; start = 1'b1;
        @(negedge clk);
        start = 1'b0; tx_data = d;
      end
      if (wt && !waited && edges == (ck ? 16 : 17)) begin
        waited = 1;
        repeat (60) @(negedge clk);
        chk(scl_oe == 1'b1, "R6 SCL held low", scl_oe, 1);
        chk(edges == (ck ? 16 : 17), "R6 no progress while held", edges, ck ? 16 : 17);
        chk(busy == 1'b1, "R6 still busy", busy, 1);
        scl_wait = 1'b0;
      end
      if (frc && guard == 50) begin
        scl_force = 1'b1;
        #1 chk(scl_oe == 1'b1, "R7 forced low at once", scl_oe, 1);
        repeat (30) @(negedge clk);
        chk(scl_oe == 1'b1, "R7 forced low held", scl_oe, 1);
        scl_force = 1'b0;
      end
    end
    chk(guard < 2000, "R11 frame completes", guard, 2000);
    repeat (4) @(negedge clk);
    if (!frc) begin
      chk(edges == 18, "R3 edge count", edges, 18);
      chk(rises == 9, "R1 rise count", rises, 9);
      chk(loads == (ck ? 2 : 1), ck ? "R5 copy count" : "R4 copy count", loads, ck ? 2 : 1);
      chk(irqs == 1, "R3 interrupt count", irqs, 1);
      if (e) chk(irqs == 1 && rises == 9, "R12 external clock frame", rises, 9);
      if (dk) chk(dchg == 8, "R9 SDA change count", dchg, 8);
    end
    chk(scl_oe == (!e && ck), frc ? "R7 clock released" : "R2 idle SCL level",
        scl_oe, (!e && ck));
    chk(busy == 1'b0, "R11 no extra frame", busy, 0);
    mon_on = 0;
  endtask

  logic [8:0] pats [6] = '{9'h155, 9'h0AA, 9'h1FF, 9'h000, 9'h123, 9'h0FE};

  initial begin
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R11 reset busy", busy, 0);
    chk(scl_oe == 1'b0, "R2 reset SCL", scl_oe, 0);
    chk(rx_load == 1'b0 && xfer_irq == 1'b0, "R3 reset pulses", xfer_irq, 0);
    chk(sda_oe == 1'b0, "R1 reset SDA", sda_oe, 0);
    rst_n = 1'b1;
    for (int ck = 0; ck < 2; ck++)
      for (int p = 0; p < 6; p++) run_frame(ck[0], 0, pats[p], 0, 0, 0, 0, 0);
    for (int ck = 0; ck < 2; ck++) begin
      run_frame(ck[0], 1, 9'h1A5, 0, 0, 0, 0, 0);
      run_frame(ck[0], 1, 9'h05B, 0, 0, 0, 0, 0);
    end
    for (int dl = 0; dl < 8; dl++) run_frame(0, 0, 9'h155, dl, 1, 0, 0, 0);
    run_frame(0, 0, 9'h0C3, 0, 0, 1, 0, 0);
    run_frame(1, 0, 9'h0C3, 0, 0, 1, 0, 0);
    run_frame(0, 0, 9'h1B7, 0, 0, 0, 1, 0);
    run_frame(1, 0, 9'h1B7, 0, 0, 0, 1, 0);
    run_frame(0, 0, 9'h0AA, 0, 0, 0, 0, 0);
    chk(sda_oe == 1'b1, "R8 driving low before disable", sda_oe, 1);
    sda_off = 1'b1;
    #1 chk(sda_oe == 1'b0, "R8 SDA floated at once", sda_oe, 0);
    @(negedge clk);
    sda_off = 1'b0;
    #1 chk(sda_oe == 1'b1, "R8 SDA drive restored", sda_oe, 1);
    run_frame(0, 0, 9'h155, 0, 0, 0, 0, 1);
    report();
  end
endmodule